// File: doc/BRIEF.md
# Serial Character Transmitter with Break Generation

This block turns queued characters into asynchronous serial frames on a single output line. Characters are written into a small internal queue. Whenever the transmitter is idle and enabled, it takes the oldest character and sends it as one low start bit, then the data bits least-significant first, an optional ninth bit, and a high stop period. All timing comes from `tick16`, a one-cycle pulse supplied from outside at sixteen times the bit rate. Every bit lasts sixteen ticks.

A 4-bit format code selects the character layout: 7 or 8 data bits, 8 bits with odd or even parity, or 9 bits whose top bit comes from the written word. A 2-bit code selects a stop period of one, one and a half or two bit times. The line can be inverted as a whole.

Two controls act on the line outside the normal character flow. A one-cycle request arms a line break, which is sent ahead of the next character; the hardware withdraws the request once the break has been sent. A level override holds the line at its active level while the serialiser keeps running underneath. Dropping the enable returns the serialiser to idle at once but keeps the queue.

Top module: `uart_tx_break`

## Requirements
- R1: With `inv_tx`=0 the idle line is 1. With `inv_tx`=1 the idle line is 0, and every level of the frame, break and override is inverted.
- R2: A frame starts with one start bit at logic 0 and sends data bits least-significant first. Each bit lasts exactly 16 `tick16` pulses. The stop period is at logic 1.
- R3: `fmt` selects the layout. 4'b0001 sends `wr_char[6:0]`. 4'b0010 sends `wr_char[7:0]` and then a bit that makes the count of ones across the nine bits odd. 4'b0011 does the same with an even count. 4'b0100 sends all nine bits with `wr_char[8]` last. 4'b0000 and every other code send `wr_char[7:0]`.
- R4: `stop_code` sets the stop period: 2'b00 is 16 ticks, 2'b01 is 24 ticks, and 2'b10 or 2'b11 is 32 ticks. The code is taken when the character is loaded.
- R5: `busy` rises on the tick that starts a transmission and falls on the tick that ends the last stop period. It stays at 0 while idle.
- R6: While `force_active`=1, `txd` is at the active level (0 normally, 1 when inverted), whatever the serialiser is doing. The serialiser's timing is not disturbed by the override.
- R7: A pulse on `brk_set` raises `brk_pending`. The next transmission then begins with 13 bit periods at logic 0 and one bit period at logic 1, followed by the queued character. `brk_pending` falls when the break ends. No break starts while the queue is empty.
- R8: Taking `tx_en` low returns the serialiser to idle by the next cycle: `busy` is 0 and the line is at idle. The character in flight is dropped, and the characters still queued are kept and sent once `tx_en` returns.
- R9: The queue holds 4 characters and `fifo_full` is 1 while it holds 4. A write while full is dropped. Characters leave in the order they were written.
- R10: A transmission begins on a `tick16` pulse when the serialiser is idle, `tx_en`=1 and the queue holds a character. After a stop period there is therefore at least one tick of idle line before the next start bit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmit enable; low holds the serialiser in idle |
| fmt | input | 4 | Character format code |
| stop_code | input | 2 | Stop period select |
| inv_tx | input | 1 | Invert the output line |
| force_active | input | 1 | Hold the line at its active level |
| brk_set | input | 1 | One-cycle request to send a break before the next character |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_char | input | 9 | Character to queue |
| fifo_full | output | 1 | Queue holds its maximum number of characters |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A break or frame is in progress |
| brk_pending | output | 1 | Break request armed and not yet completed |

## Verification
The properties assume that `tick16` is a one-cycle pulse with at least one idle cycle between pulses. They also assume that `fmt`, `stop_code` and `inv_tx` change only while the line is idle, and that `brk_set` is a single-cycle strobe. The stimulus drives each tick as one high cycle followed by three low cycles. It changes format, stop code and polarity only between frames, and it drives the override and the enable only on falling clock edges. Levels are sampled at the middle of each bit period, counted in ticks from the tick that raised `busy`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W          = 9;
    localparam int TICKS_PER_BIT   = 16;
    localparam int BRK_ACTIVE_BITS = 13;
    localparam int BRK_TOTAL_BITS  = BRK_ACTIVE_BITS + 1;
    localparam int TCNT_W          = 6;
    localparam int BCNT_W          = 4;

    localparam logic [3:0] FMT_8N    = 4'b0000;
    localparam logic [3:0] FMT_7N    = 4'b0001;
    localparam logic [3:0] FMT_8ODD  = 4'b0010;
    localparam logic [3:0] FMT_8EVEN = 4'b0011;
    localparam logic [3:0] FMT_9BIT  = 4'b0100;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_BREAK,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] bits;
        logic [BCNT_W-1:0] nbits;
        logic [TCNT_W-1:0] stop_len;
    } frame_t;

    function automatic logic [TCNT_W-1:0] stop_len_ticks(input logic [1:0] code);
        case (code)
            2'b00:   return TCNT_W'(TICKS_PER_BIT);
            2'b01:   return TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
            default: return TCNT_W'(2 * TICKS_PER_BIT);
        endcase
    endfunction

    function automatic frame_t build_frame(input logic [3:0] fmt,
                                           input logic [1:0] stop_code,
                                           input logic [CHAR_W-1:0] ch);
        frame_t f;
        f.stop_len = stop_len_ticks(stop_code);
        case (fmt)
            FMT_7N: begin
                f.bits  = {2'b00, ch[6:0]};
                f.nbits = BCNT_W'(7);
            end
            FMT_8ODD: begin
                f.bits  = {~(^ch[7:0]), ch[7:0]};
                f.nbits = BCNT_W'(9);
            end
            FMT_8EVEN: begin
                f.bits  = {^ch[7:0], ch[7:0]};
                f.nbits = BCNT_W'(9);
            end
            FMT_9BIT: begin
                f.bits  = ch;
                f.nbits = BCNT_W'(9);
            end
            default: begin
                f.bits  = {1'b0, ch[7:0]};
                f.nbits = BCNT_W'(8);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic             wr_fire;

    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign wr_fire = wr_valid && !full;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_fire) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic [3:0]        fmt,
    input  logic [1:0]        stop_code,
    input  logic              brk_set,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_char,
    output logic              fifo_pop,
    output logic              line_mark,
    output logic              busy,
    output logic              brk_pending
);
    tx_state_e         state;
    logic [TCNT_W-1:0] tcnt;
    logic [BCNT_W-1:0] bidx;
    frame_t            cur;

    logic bit_end;
    logic idle_go;
    logic begin_break;
    logic break_done;
    logic begin_char;
    logic last_data;
    logic stop_end;

    always_comb begin
        bit_end     = tick && (tcnt == TCNT_W'(TICKS_PER_BIT - 1));
        idle_go     = tx_en && (state == TX_IDLE) && tick && !fifo_empty;
        begin_break = idle_go && brk_pending;
        break_done  = tx_en && (state == TX_BREAK) && bit_end
                      && (bidx == BCNT_W'(BRK_TOTAL_BITS - 1));
        begin_char  = (idle_go && !brk_pending) || break_done;
        last_data   = (bidx == cur.nbits - 1'b1);
        stop_end    = tick && (tcnt == cur.stop_len - 1'b1);
        fifo_pop    = begin_char;
        busy        = (state != TX_IDLE);
    end

    always_comb begin
        case (state)
            TX_BREAK: line_mark = (bidx >= BCNT_W'(BRK_ACTIVE_BITS));
            TX_START: line_mark = 1'b0;
            TX_DATA:  line_mark = cur.bits[0];
            default:  line_mark = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            cur   <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    tcnt <= '0;
                    bidx <= '0;
                    if (begin_break) begin
                        state <= TX_BREAK;
                    end else if (begin_char) begin
                        state <= TX_START;
                        cur   <= build_frame(fmt, stop_code, fifo_char);
                    end
                end
                TX_BREAK: begin
                    if (bit_end) begin
                        tcnt <= '0;
                        if (break_done) begin
                            state <= TX_START;
                            bidx  <= '0;
                            cur   <= build_frame(fmt, stop_code, fifo_char);
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        state <= TX_DATA;
                        tcnt  <= '0;
                        bidx  <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        tcnt     <= '0;
                        cur.bits <= cur.bits >> 1;
                        if (last_data) begin
                            state <= TX_STOP;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (stop_end) begin
                        state <= TX_IDLE;
                        tcnt  <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_pending <= 1'b0;
        end else if (brk_set) begin
            brk_pending <= 1'b1;
        end else if (break_done) begin
            brk_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/utx_line_drv.sv
module utx_line_drv (
    input  logic line_mark,
    input  logic inv_tx,
    input  logic force_active,
    output logic txd
);
    logic level;

    always_comb begin
        level = force_active ? 1'b0 : line_mark;
        txd   = level ^ inv_tx;
    end
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic [3:0]        fmt,
    input  logic [1:0]        stop_code,
    input  logic              inv_tx,
    input  logic              force_active,
    input  logic              brk_set,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_char,
    output logic              fifo_full,
    output logic              txd,
    output logic              busy,
    output logic              brk_pending
);
    logic              fifo_empty;
    logic              fifo_pop;
    logic [CHAR_W-1:0] fifo_char;
    logic              line_mark;

    utx_fifo #(
        .WIDTH (CHAR_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_char),
        .rd_en    (fifo_pop),
        .rd_data  (fifo_char),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    utx_framer i_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .tx_en       (tx_en),
        .fmt         (fmt),
        .stop_code   (stop_code),
        .brk_set     (brk_set),
        .fifo_empty  (fifo_empty),
        .fifo_char   (fifo_char),
        .fifo_pop    (fifo_pop),
        .line_mark   (line_mark),
        .busy        (busy),
        .brk_pending (brk_pending)
    );

    utx_line_drv i_drv (
        .line_mark    (line_mark),
        .inv_tx       (inv_tx),
        .force_active (force_active),
        .txd          (txd)
    );
endmodule

// File: rtl/uart_tx_break_chk.sv
module uart_tx_break_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic inv_tx,
    input logic force_active,
    input logic busy,
    input logic brk_pending,
    input logic txd
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && !force_active) |-> (txd == !inv_tx)); // R1

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !force_active) |-> (txd == inv_tx)); // R2

    AST_FORCE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        force_active |-> (txd == inv_tx)); // R6

    AST_BRK_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_pending) |-> busy); // R7

    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (brk_pending && !busy) |=> brk_pending); // R7

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !busy); // R8
endmodule

bind uart_tx_break uart_tx_break_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_en        (tx_en),
    .inv_tx       (inv_tx),
    .force_active (force_active),
    .busy         (busy),
    .brk_pending  (brk_pending),
    .txd          (txd)
);

// File: tb/test_uart_tx_break.sv
module test_uart_tx_break;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] fmt = 4'b0000;
    logic [1:0] stop_code = 2'b00;
    logic       inv_tx = 1'b0;
    logic       force_active = 1'b0;
    logic       brk_set = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_char = '0;
    logic       fifo_full;
    logic       txd;
    logic       busy;
    logic       brk_pending;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_pos = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    uart_tx_break i_uart_tx_break (
        .clk          (clk),
        .rst          (rst),
        .tick16       (tick16),
        .tx_en        (tx_en),
        .fmt          (fmt),
        .stop_code    (stop_code),
        .inv_tx       (inv_tx),
        .force_active (force_active),
        .brk_set      (brk_set),
        .wr_valid     (wr_valid),
        .wr_char      (wr_char),
        .fifo_full    (fifo_full),
        .txd          (txd),
        .busy         (busy),
        .brk_pending  (brk_pending)
    );

    // {fmt[3:0], stop_code[1:0], inv_tx, wr_char[8:0]}
    localparam logic [15:0] VEC [9] = '{
        {4'b0000, 2'b00, 1'b0, 9'h0A5},
        {4'b0001, 2'b00, 1'b0, 9'h05A},
        {4'b0010, 2'b01, 1'b0, 9'h0B3},
        {4'b0011, 2'b10, 1'b0, 9'h0B3},
        {4'b0100, 2'b11, 1'b0, 9'h155},
        {4'b0000, 2'b01, 1'b1, 9'h03C},
        {4'b0011, 2'b00, 1'b1, 9'h000},
        {4'b0010, 2'b10, 1'b0, 9'h000},
        {4'b1111, 2'b00, 1'b0, 9'h1C3}
    };

    function automatic int exp_nbits(input logic [3:0] m);
        if (m == 4'b0001) return 7;
        if (m == 4'b0010 || m == 4'b0011 || m == 4'b0100) return 9;
        return 8;
    endfunction

    function automatic logic exp_bit(input logic [3:0] m, input logic [8:0] d, input int i);
        int ones;
        if (i < 8) return d[i];
        if (m == 4'b0100) return d[8];
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(d[k]);
        if (m == 4'b0010) return (ones % 2 == 0);
        return (ones % 2 == 1);
    endfunction

    function automatic int exp_stop(input logic [1:0] c);
        if (c == 2'b00) return 16;
        if (c == 2'b01) return 24;
        return 32;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic advance_to(input int t);
        while (tick_pos < t) begin
            do_tick();
            tick_pos++;
        end
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_char  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_start(input string req);
        tick_pos = 0;
        for (int k = 0; k < 40; k++) begin
            do_tick();
            if (busy) break;
        end
        chk(req, "busy at start", int'(busy), 1);
    endtask

    task automatic check_frame(input logic [3:0] m, input logic [1:0] sc, input logic inv,
                               input logic [8:0] d, input bit brk);
        int base;
        int nd;
        int sb;
        int len;
        base = 0;
        wait_start("R10");
        if (brk) begin
            for (int i = 0; i < 14; i++) begin
                advance_to(8 + 16 * i);
                chk("R7", "break bit level", int'(txd), int'((i < 13 ? 1'b0 : 1'b1) ^ inv));
            end
            advance_to(223);
            chk("R7", "request held in break", int'(brk_pending), 1);
            advance_to(224);
            chk("R7", "request cleared after break", int'(brk_pending), 0);
            base = 224;
        end
        nd = exp_nbits(m);
        advance_to(base + 8);
        chk("R2", "start bit", int'(txd), int'(inv));
        for (int i = 0; i < nd; i++) begin
            advance_to(base + 8 + 16 * (i + 1));
            chk("R3", "data bit", int'(txd), int'(exp_bit(m, d, i) ^ inv));
        end
        sb  = base + 16 * (nd + 1);
        len = exp_stop(sc);
        advance_to(sb + 8);
        chk("R2", "stop level", int'(txd), int'(!inv));
        advance_to(sb + len - 1);
        chk("R5", "busy before stop end", int'(busy), 1);
        advance_to(sb + len);
        chk("R4", "busy after stop length", int'(busy), 0);
        chk("R1", "idle after frame", int'(txd), int'(!inv));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1", "reset idle line", int'(txd), 1);
        chk("R5", "reset busy", int'(busy), 0);
        chk("R9", "reset full", int'(fifo_full), 0);
        chk("R7", "reset break request", int'(brk_pending), 0);
        inv_tx = 1'b1;
        @(negedge clk);
        chk("R1", "inverted idle line", int'(txd), 0);
        inv_tx = 1'b0;
        tx_en  = 1'b1;

        // format, stop length and polarity vectors
        for (int v = 0; v < 9; v++) begin
            fmt       = VEC[v][15:12];
            stop_code = VEC[v][11:10];
            inv_tx    = VEC[v][9];
            @(negedge clk);
            chk("R1", "idle level per vector", int'(txd), int'(!inv_tx));
            push(VEC[v][8:0]);
            check_frame(VEC[v][15:12], VEC[v][11:10], VEC[v][9], VEC[v][8:0], 1'b0);
        end
        fmt = 4'b0000;
        stop_code = 2'b00;
        inv_tx = 1'b0;

        // R7: break armed with an empty queue waits, then precedes the character
        @(negedge clk) brk_set = 1'b1;
        @(negedge clk) brk_set = 1'b0;
        chk("R7", "request raised", int'(brk_pending), 1);
        for (int k = 0; k < 20; k++) do_tick();
        chk("R7", "no break without data", int'(busy), 0);
        chk("R7", "request kept while idle", int'(brk_pending), 1);
        push(9'h0C3);
        check_frame(4'b0000, 2'b00, 1'b0, 9'h0C3, 1'b1);

        // R6: override during a frame and while idle
        push(9'h0FF);
        wait_start("R6");
        advance_to(8 + 16 * 3);
        force_active = 1'b1;
        #1;
        chk("R6", "override active level", int'(txd), 0);
        @(negedge clk);
        force_active = 1'b0;
        #1;
        chk("R6", "shifter level after release", int'(txd), 1);
        advance_to(16 * 9 + 15);
        chk("R6", "timing kept busy", int'(busy), 1);
        advance_to(16 * 9 + 16);
        chk("R6", "timing kept end", int'(busy), 0);
        inv_tx = 1'b1;
        force_active = 1'b1;
        @(negedge clk);
        chk("R6", "override inverted", int'(txd), 1);
        force_active = 1'b0;
        inv_tx = 1'b0;

        // R9: queue depth, drop on full, order
        tx_en = 1'b0;
        push(9'h011);
        push(9'h022);
        push(9'h033);
        chk("R9", "not full at 3", int'(fifo_full), 0);
        push(9'h044);
        chk("R9", "full at 4", int'(fifo_full), 1);
        push(9'h055);
        chk("R8", "no start while disabled", int'(busy), 0);
        tx_en = 1'b1;
        check_frame(4'b0000, 2'b00, 1'b0, 9'h011, 1'b0);
        check_frame(4'b0000, 2'b00, 1'b0, 9'h022, 1'b0);
        check_frame(4'b0000, 2'b00, 1'b0, 9'h033, 1'b0);
        check_frame(4'b0000, 2'b00, 1'b0, 9'h044, 1'b0);
        for (int k = 0; k < 30; k++) do_tick();
        chk("R9", "dropped write not sent", int'(busy), 0);

        // R8: abort mid-frame keeps the queue
        tx_en = 1'b0;
        push(9'h0F0);
        push(9'h00F);
        tx_en = 1'b1;
        wait_start("R8");
        advance_to(40);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R8", "busy cleared on disable", int'(busy), 0);
        chk("R8", "line idle on disable", int'(txd), 1);
        for (int k = 0; k < 20; k++) do_tick();
        chk("R8", "held idle while disabled", int'(busy), 0);
        tx_en = 1'b1;
        check_frame(4'b0000, 2'b00, 1'b0, 9'h00F, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule